// File: doc/BRIEF.md
# Shared-Pool Multi-Queue FIFO

This block keeps up to four independent first-in first-out queues inside one shared word-wide memory. At master reset each queue is given a capacity as a whole number of fixed-size allocation blocks. The queues are packed back to back in the pool. A queue given zero blocks is unused. One clock domain serves both ports. On every clock, one word can be written into the queue selected on the write side and one word can be taken from the queue selected on the read side.

Each port picks its queue with an address bus and an address-enable strobe. The two ports choose independently. A write-side switch takes effect after a fixed pipeline delay. A read-side switch takes effect at once. The read side works in first-word-fall-through style, so the head word of the selected queue is already on the output with a valid flag. Full, almost-full and almost-empty flags are given for the selected queues. Two vectors give the almost-full and almost-empty state of every queue at all times. A partial reset empties one chosen queue.

Top module: `mq_fifo`

## Requirements
- R1: Configuration is captured on the first rising edge after reset is released. Queue q gets `BLK_WORDS` times its 4-bit count in `cfg_blk_i[4q+3:4q]`. A queue with count 0 is unused: it reads as full, never accepts a word and never shows valid data. In reset every queue reads as zero-sized: `full_o` is high, `ov_o` is low and all almost flags are high.
- R2: A word written into the empty queue that the read port has selected appears on `rd_data_o`, with `ov_o` high, right after the write edge.
- R3: Each queue delivers words in the order they were written. A write and a read can both complete on the same clock, on the same queue or on different queues.
- R4: Raising `wr_sel_i` with a queue number on `wr_addr_i` redirects the write port. Writes in the selection cycle and on the next two rising edges are ignored. Writes are accepted from the third rising edge after the selection edge. `full_o` and `paf_o` switch to the new queue on the second edge after it.
- R5: Raising `rd_sel_i` redirects the read port. A read made in the selection cycle still takes the head of the previous queue. The new queue's head is presented right after that edge.
- R6: `ov_o` goes low right after the edge that consumes the last word of the selected queue.
- R7: `full_o` is high when the write-selected queue holds its capacity. Writes while it is high are ignored and change no pointer.
- R8: A read while `ov_o` is low is ignored and changes no pointer.
- R9: The offset is `OFF_LO` (8) when `cfg_off_sel_i` is 0 at configuration and `OFF_HI` (128) when it is 1. `paf_o` is high when the free space of the write queue is at most the offset. `pae_o` is high when the fill of the read queue is at most the offset.
- R10: Bit q of `paf_vec_o` and bit q of `pae_vec_o` give the almost-full and almost-empty state of queue q at all times, whatever queue each port has selected.
- R11: A partial reset (`prs_i` with `prs_q_i`) empties the named queue on the next edge. It overrides a write or read to that queue on that edge and leaves the other queues untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| cfg_blk_i | input | 4*BCW (16) | Block count per queue, queue q at bits [BCW*q +: BCW] |
| cfg_off_sel_i | input | 1 | Almost-flag offset select: 0 low offset, 1 high offset |
| wr_sel_i | input | 1 | Write queue address enable |
| wr_addr_i | input | 2 | Write queue number |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Write data |
| rd_sel_i | input | 1 | Read queue address enable |
| rd_addr_i | input | 2 | Read queue number |
| rd_en_i | input | 1 | Read request (consumes the presented word) |
| prs_i | input | 1 | Partial reset request |
| prs_q_i | input | 2 | Queue to clear |
| rd_data_o | output | DW | Head word of the read queue |
| ov_o | output | 1 | Output valid |
| full_o | output | 1 | Write queue full |
| paf_o | output | 1 | Write queue almost full |
| pae_o | output | 1 | Read queue almost empty |
| paf_vec_o | output | 4 | Almost-full state of every queue |
| pae_vec_o | output | 4 | Almost-empty state of every queue |

## Verification
Some rules are checked on every cycle by assertions:
- the write blackout after a write-side selection;
- no queue count ever exceeding its capacity;
- read pointers that stay still when a read hits an empty output;
- a partial reset leaving its queue empty on the next edge.

Other behaviour only the bench's scenarios can show:
- data order and the bypass timing of the first word;
- which queue's head appears after a read-side switch;
- flag thresholds under both offsets;
- the unused zero-block queue;
- other queues surviving a partial reset.

The bench shows these by comparing against a behavioural model on every clock, under directed sequences and randomised traffic.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int unsigned MQ_NQ = 4;
  localparam int unsigned MQ_QW = 2;
  typedef logic [MQ_QW-1:0] qid_t;
  typedef struct packed {
    logic vld;
    qid_t q;
  } qop_t;
endpackage

// File: rtl/mq_port_sel.sv
module mq_port_sel
  import mq_pkg::*;
#(
  parameter int unsigned HOLD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  qid_t addr_i,
  output qid_t act_o,
  output logic ready_o
);
  qid_t act_q;
  assign act_o = act_q;

  generate
    if (HOLD == 0) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) act_q <= '0;
        else if (sel_i) act_q <= addr_i;
      end
      assign ready_o = 1'b1;
    end else begin : g_hold
      localparam int unsigned HW = $clog2(HOLD + 1);
      logic [HW-1:0] hold_q;
      qid_t          pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hold_q <= '0;
          pend_q <= '0;
          act_q  <= '0;
        end else if (sel_i) begin
          hold_q <= HW'(HOLD);
          pend_q <= addr_i;
        end else if (hold_q != '0) begin
          hold_q <= hold_q - HW'(1);
          if (hold_q == HW'(1)) act_q <= pend_q;
        end
      end
      assign ready_o = (hold_q == '0) && !sel_i;
    end
  endgenerate
endmodule

// File: rtl/mq_qstate.sv
module mq_qstate
  import mq_pkg::*;
#(
  parameter int unsigned NQ        = MQ_NQ,
  parameter int unsigned BLK_WORDS = 32,
  parameter int unsigned NBLK      = 8,
  localparam int unsigned DEPTH    = BLK_WORDS * NBLK,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned CW       = AW + 1,
  localparam int unsigned BCW      = $clog2(NBLK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NQ*BCW-1:0] cfg_blk_i,
  input  qop_t              wr_op_i,
  input  qop_t              rd_op_i,
  input  qop_t              prs_op_i,
  output logic              cfg_done_o,
  output logic [AW-1:0]     base_o   [NQ],
  output logic [CW-1:0]     lim_o    [NQ],
  output logic [CW-1:0]     cnt_o    [NQ],
  output logic [CW-1:0]     wptr_o   [NQ],
  output logic [CW-1:0]     rptr_o   [NQ],
  output logic [CW-1:0]     rptr_n_o [NQ],
  output logic [CW-1:0]     cnt_n_o  [NQ]
);
  logic          cfg_done_q;
  logic [AW-1:0] base_c [NQ];
  logic [CW-1:0] lim_c  [NQ];
  logic [CW-1:0] acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_done_q <= 1'b0;
    else         cfg_done_q <= 1'b1;
  end
  assign cfg_done_o = cfg_done_q;

  // queues packed back to back in index order
  always_comb begin
    acc = '0;
    for (int i = 0; i < NQ; i++) begin
      base_c[i] = AW'(acc);
      lim_c[i]  = CW'(cfg_blk_i[i*BCW +: BCW]) * CW'(BLK_WORDS);
      acc       = acc + lim_c[i];
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic          wr_hit, rd_hit, prs_hit;
    logic [AW-1:0] base_q;
    logic [CW-1:0] lim_q, cnt_q, wptr_q, rptr_q;
    logic [CW-1:0] cnt_n, wptr_n, rptr_n;

    assign wr_hit  = wr_op_i.vld  && (wr_op_i.q  == qid_t'(g));
    assign rd_hit  = rd_op_i.vld  && (rd_op_i.q  == qid_t'(g));
    assign prs_hit = prs_op_i.vld && (prs_op_i.q == qid_t'(g));

    always_comb begin
      cnt_n  = cnt_q;
      wptr_n = wptr_q;
      rptr_n = rptr_q;
      if (prs_hit) begin
        cnt_n  = '0;
        wptr_n = '0;
        rptr_n = '0;
      end else begin
        if (wr_hit) wptr_n = (wptr_q == lim_q - CW'(1)) ? '0 : wptr_q + CW'(1);
        if (rd_hit) rptr_n = (rptr_q == lim_q - CW'(1)) ? '0 : rptr_q + CW'(1);
        cnt_n = cnt_q + CW'(wr_hit) - CW'(rd_hit);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        lim_q  <= '0;
        cnt_q  <= '0;
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        if (!cfg_done_q) begin
          base_q <= base_c[g];
          lim_q  <= lim_c[g];
        end
        cnt_q  <= cnt_n;
        wptr_q <= wptr_n;
        rptr_q <= rptr_n;
      end
    end

    assign base_o[g]   = base_q;
    assign lim_o[g]    = lim_q;
    assign cnt_o[g]    = cnt_q;
    assign wptr_o[g]   = wptr_q;
    assign rptr_o[g]   = rptr_q;
    assign rptr_n_o[g] = rptr_n;
    assign cnt_n_o[g]  = cnt_n;
  end
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
  import mq_pkg::*;
#(
  parameter int unsigned DW        = 36,
  parameter int unsigned BLK_WORDS = 32,
  parameter int unsigned NBLK      = 8,
  parameter int unsigned OFF_LO    = 8,
  parameter int unsigned OFF_HI    = 128,
  localparam int unsigned NQ       = MQ_NQ,
  localparam int unsigned DEPTH    = BLK_WORDS * NBLK,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned CW       = AW + 1,
  localparam int unsigned BCW      = $clog2(NBLK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NQ*BCW-1:0] cfg_blk_i,
  input  logic              cfg_off_sel_i,
  input  logic              wr_sel_i,
  input  logic [MQ_QW-1:0]  wr_addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_sel_i,
  input  logic [MQ_QW-1:0]  rd_addr_i,
  input  logic              rd_en_i,
  input  logic              prs_i,
  input  logic [MQ_QW-1:0]  prs_q_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              ov_o,
  output logic              full_o,
  output logic              paf_o,
  output logic              pae_o,
  output logic [NQ-1:0]     paf_vec_o,
  output logic [NQ-1:0]     pae_vec_o
);
  qid_t          wq, rq, pq;
  logic          wr_ready, rd_ready, cfg_done;
  logic          wr_fire, rd_fire, w_full;
  qop_t          wr_op, rd_op, prs_op;
  logic [AW-1:0] base_w [NQ];
  logic [CW-1:0] lim_w [NQ], cnt_w [NQ], wptr_w [NQ], rptr_w [NQ];
  logic [CW-1:0] rptr_n_w [NQ], cnt_n_w [NQ];
  logic [CW-1:0] off_q;
  logic [AW-1:0] wa, pa;
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_data_q;
  logic          ov_q;

  mq_port_sel #(.HOLD(2)) u_wsel (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(wr_sel_i), .addr_i(wr_addr_i),
    .act_o(wq), .ready_o(wr_ready)
  );

  mq_port_sel #(.HOLD(0)) u_rsel (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(rd_sel_i), .addr_i(rd_addr_i),
    .act_o(rq), .ready_o(rd_ready)
  );

  mq_qstate #(.NQ(NQ), .BLK_WORDS(BLK_WORDS), .NBLK(NBLK)) u_qs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_blk_i(cfg_blk_i),
    .wr_op_i(wr_op), .rd_op_i(rd_op), .prs_op_i(prs_op),
    .cfg_done_o(cfg_done), .base_o(base_w), .lim_o(lim_w), .cnt_o(cnt_w),
    .wptr_o(wptr_w), .rptr_o(rptr_w), .rptr_n_o(rptr_n_w), .cnt_n_o(cnt_n_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       off_q <= '0;
    else if (!cfg_done) off_q <= cfg_off_sel_i ? CW'(OFF_HI) : CW'(OFF_LO);
  end

  assign w_full  = (cnt_w[wq] == lim_w[wq]);
  assign wr_fire = cfg_done && wr_en_i && wr_ready && !w_full;
  assign rd_fire = cfg_done && rd_en_i && rd_ready && (cnt_w[rq] != '0);
  assign wr_op   = '{vld: wr_fire, q: wq};
  assign rd_op   = '{vld: rd_fire, q: rq};
  assign prs_op  = '{vld: prs_i && cfg_done, q: prs_q_i};

  assign wa = base_w[wq] + AW'(wptr_w[wq]);
  // peek the queue that will be selected after this edge
  assign pq = rd_sel_i ? rd_addr_i : rq;
  assign pa = base_w[pq] + AW'(rptr_n_w[pq]);

  always_ff @(posedge clk_i) begin
    if (wr_fire) mem_q[wa] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
      ov_q      <= 1'b0;
    end else begin
      rd_data_q <= (wr_fire && wa == pa) ? wr_data_i : mem_q[pa];
      ov_q      <= (cnt_n_w[pq] != '0);
    end
  end

  assign rd_data_o = rd_data_q;
  assign ov_o      = ov_q;
  assign full_o    = w_full;
  assign paf_o     = (lim_w[wq] - cnt_w[wq]) <= off_q;
  assign pae_o     = cnt_w[rq] <= off_q;

  for (genvar g = 0; g < NQ; g++) begin : g_flag
    assign paf_vec_o[g] = (lim_w[g] - cnt_w[g]) <= off_q;
    assign pae_vec_o[g] = cnt_w[g] <= off_q;
  end
endmodule

// File: rtl/mq_fifo_chk.sv
module mq_fifo_chk #(
  parameter int unsigned NQ = 4,
  parameter int unsigned CW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_sel_i,
  input logic          wr_fire,
  input logic          rd_en_i,
  input logic          ov_o,
  input logic          prs_i,
  input logic [1:0]    prs_q_i,
  input logic [CW-1:0] cnt_i  [NQ],
  input logic [CW-1:0] lim_i  [NQ],
  input logic [CW-1:0] rptr_i [NQ]
);
  // R4: selection cycle and the two edges after it take no write
  a_r4_sel_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel_i |-> !wr_fire);
  a_r4_first_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel_i |=> !wr_fire);
  a_r4_second_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_sel_i) |=> !wr_fire);
  // R11: named queue empty after partial reset
  a_r11_prs_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prs_i |=> (cnt_i[$past(prs_q_i)] == '0));

  for (genvar g = 0; g < NQ; g++) begin : g_q
    a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i[g] <= lim_i[g]);
    a_r8_empty_read_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !ov_o && !prs_i) |=> $stable(rptr_i[g]));
  end
endmodule

bind mq_fifo mq_fifo_chk #(.NQ(NQ), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_sel_i(wr_sel_i), .wr_fire(wr_fire),
  .rd_en_i(rd_en_i), .ov_o(ov_o), .prs_i(prs_i), .prs_q_i(prs_q_i),
  .cnt_i(cnt_w), .lim_i(lim_w), .rptr_i(rptr_w)
);

// File: tb/tb_mq_fifo.sv
module tb_mq_fifo;
  localparam int DW = 36, NQ = 4, BLKW = 32, OFF_LO = 8, OFF_HI = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   cfg_blk_i = 16'h0121;
  logic          cfg_off_sel_i = 1'b0;
  logic          wr_sel_i = 1'b0, rd_sel_i = 1'b0, prs_i = 1'b0;
  logic [1:0]    wr_addr_i = '0, rd_addr_i = '0, prs_q_i = '0;
  logic          wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          ov_o, full_o, paf_o, pae_o;
  logic [3:0]    paf_vec_o, pae_vec_o;

  mq_fifo dut (.*);

  always #2 clk_i = ~clk_i;  // 4 time units = 250 MHz

  // reference model
  logic [DW-1:0] mq [NQ][$];
  int  lim_m [NQ];
  int  off_m, wq_m, wpend_m, whold_m, rq_m;
  bit  cfg_m, ov_m;
  logic [DW-1:0] dat_m;
  int  n_chk = 0, n_bad = 0;
  int unsigned seq = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin mq[q].delete(); lim_m[q] = 0; end
    off_m = 0; wq_m = 0; wpend_m = 0; whold_m = 0; rq_m = 0; cfg_m = 0; ov_m = 0;
  endtask

  task automatic model_edge();
    bit wf, rf;
    if (!cfg_m) begin
      for (int q = 0; q < NQ; q++) lim_m[q] = int'(cfg_blk_i[q*4 +: 4]) * BLKW;
      off_m = cfg_off_sel_i ? OFF_HI : OFF_LO;
      cfg_m = 1;
    end else begin
      wf = wr_en_i && !wr_sel_i && whold_m == 0 && mq[wq_m].size() < lim_m[wq_m];
      rf = rd_en_i && mq[rq_m].size() > 0;
      if (rf) void'(mq[rq_m].pop_front());
      if (wf) mq[wq_m].push_back(wr_data_i);
      if (prs_i) mq[int'(prs_q_i)].delete();
    end
    if (wr_sel_i) begin wpend_m = int'(wr_addr_i); whold_m = 2; end
    else if (whold_m != 0) begin
      if (whold_m == 1) wq_m = wpend_m;
      whold_m--;
    end
    if (rd_sel_i) rq_m = int'(rd_addr_i);
    ov_m = mq[rq_m].size() > 0;
    if (ov_m) dat_m = mq[rq_m][0];
  endtask

  task automatic compare_all();
    logic [3:0] pv, ev;
    for (int q = 0; q < NQ; q++) begin
      pv[q] = (lim_m[q] - mq[q].size()) <= off_m;
      ev[q] = mq[q].size() <= off_m;
    end
    check("R7 full_o", full_o, mq[wq_m].size() == lim_m[wq_m]);
    check("R9 paf_o", paf_o, (lim_m[wq_m] - mq[wq_m].size()) <= off_m);
    check("R9 pae_o", pae_o, mq[rq_m].size() <= off_m);
    check("R10 paf_vec_o", paf_vec_o, pv);
    check("R10 pae_vec_o", pae_vec_o, ev);
    check("R6 ov_o", ov_o, ov_m);
    if (ov_m) check("R3 rd_data_o", rd_data_o, dat_m);
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic cyc(input bit we, input bit re);
    wr_en_i = we; rd_en_i = re;
    if (we) begin seq++; wr_data_i = {4'hC, seq}; end
    tick();
    wr_sel_i = 0; rd_sel_i = 0; prs_i = 0; wr_en_i = 0; rd_en_i = 0;
  endtask

  task automatic do_reset(input logic [15:0] blk, input bit osel);
    @(negedge clk_i);
    rst_ni = 0; cfg_blk_i = blk; cfg_off_sel_i = osel;
    model_reset();
    @(negedge clk_i);
    compare_all();
    check("R1 reset full_o", full_o, 1);
    check("R1 reset ov_o", ov_o, 0);
    check("R1 reset pae_vec_o", pae_vec_o, 4'hF);
    rst_ni = 1;
    cyc(0, 0);
  endtask

  task automatic sel_wr(input logic [1:0] q);
    wr_sel_i = 1; wr_addr_i = q; cyc(0, 0); cyc(0, 0); cyc(0, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d_c, q1a, q1b, q2a;
    int n;
    do_reset(16'h0121, 0);
    check("R1 cfg full_o", full_o, 0);
    check("R1 unused q3 paf_vec_o", paf_vec_o, 4'b1000);

    cyc(1, 0);
    check("R2 ov_o after first write", ov_o, 1);
    check("R2 bypass data", rd_data_o, wr_data_i);
    for (int i = 0; i < 4; i++) cyc(1, 0);
    for (int i = 0; i < 10; i++) cyc(1, 1);
    for (int i = 0; i < 40; i++) cyc(1, 0);
    check("R7 full_o at capacity", full_o, 1);
    check("R9 paf_o at capacity", paf_o, 1);
    n = 0;
    while (ov_o && n < 100) begin cyc(0, 1); n++; end
    check("R7 words kept when full", n, 32);
    check("R6 ov_o after last word", ov_o, 0);
    cyc(0, 1);
    check("R8 empty read ov_o", ov_o, 0);
    cyc(1, 0);
    check("R8 data after empty read", rd_data_o, wr_data_i);
    cyc(0, 1);

    // R4 write-side switch
    wr_sel_i = 1; wr_addr_i = 1; cyc(1, 0);
    cyc(1, 0); cyc(1, 0); cyc(1, 0); d_c = wr_data_i;
    check("R4 q0 untouched", ov_o, 0);
    rd_sel_i = 1; rd_addr_i = 1; cyc(0, 0);
    check("R4 first accepted word", rd_data_o, d_c);

    // R5 read-side switch
    cyc(1, 0); q1a = wr_data_i; cyc(1, 0); q1b = wr_data_i;
    sel_wr(2);
    cyc(1, 0); q2a = wr_data_i; cyc(1, 0);
    rd_sel_i = 1; rd_addr_i = 2; cyc(0, 1);
    check("R5 new queue head", rd_data_o, q2a);
    rd_sel_i = 1; rd_addr_i = 1; cyc(0, 0);
    check("R5 old queue popped", rd_data_o, q1a);

    // R11 partial reset of q1
    prs_i = 1; prs_q_i = 1; cyc(0, 0);
    check("R11 cleared queue ov_o", ov_o, 0);
    rd_sel_i = 1; rd_addr_i = 2; cyc(0, 0);
    check("R11 other queue intact", rd_data_o, q2a);

    // R10 status vectors
    for (int i = 0; i < 22; i++) cyc(1, 0);
    check("R10 paf_vec_o", paf_vec_o, 4'b1100);
    check("R10 pae_vec_o", pae_vec_o, 4'b1011);

    // R1 unused queue
    sel_wr(3);
    cyc(1, 0); cyc(1, 0);
    check("R1 unused full_o", full_o, 1);
    rd_sel_i = 1; rd_addr_i = 3; cyc(0, 0);
    check("R1 unused ov_o", ov_o, 0);
    if (q1b == '0) n_chk++;

    // randomised traffic
    for (int i = 0; i < 800; i++) begin
      wr_sel_i = ($urandom % 16) == 0; wr_addr_i = 2'($urandom);
      rd_sel_i = ($urandom % 16) == 0; rd_addr_i = 2'($urandom);
      prs_i = ($urandom % 64) == 0; prs_q_i = 2'($urandom);
      cyc(($urandom % 3) != 0, ($urandom % 2) != 0);
    end

    // R9 high offset
    do_reset(16'h0008, 1);
    for (int i = 0; i < 127; i++) cyc(1, 0);
    check("R9 high offset paf_o 127", paf_o, 0);
    check("R9 high offset pae_o 127", pae_o, 1);
    cyc(1, 0);
    check("R9 high offset paf_o 128", paf_o, 1);
    cyc(1, 0);
    check("R9 high offset pae_o 129", pae_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule